// File: doc/BRIEF.md
# Epoch-Ordered Request Sequencer

This block sits at a router's ejection port in a multicore mesh. Coherence requests reach it over an unordered network, late and in any order. The sequencer turns them back into one global order, so a broadcast snooping protocol can still rely on every node seeing the same request sequence.

A separate lightweight notification network delivers one bitmask per epoch, at the epoch boundary. The mask marks every core that injected a request during that epoch, and the masks from all cores are merged by bitwise OR. The sequencer keeps a short queue of these masks. Each arriving request packet carries its source core and epoch tag, and the sequencer parks it in a slot for that epoch and source. Requests leave through a valid/ready port toward the local cache controller. Within an epoch they leave in a rotating core-priority order. One epoch is fully drained before the next one starts.

Top module: `epochSequencer`

## Requirements
- R1: While reset is held, and right after it, `outValid`, `maskStall` and `errFlag` are all 0.
- R2: A mask is accepted in a cycle with `maskValid` high and `maskStall` low. The k-th mask accepted since reset (k from 0) belongs to epoch k, and its packets carry the tag k mod 2^EPOCH_W in `pktEpoch`. A released request shows the payload that came with it.
- R3: `maskStall` is high exactly while four epochs are pending, meaning accepted and not yet retired. A mask offered while `maskStall` is high is ignored and takes no epoch number.
- R4: In epoch k, core (k mod 36) has the highest priority. Priority then falls through increasing core index and wraps from 35 to 0. A marked request is held until every higher-priority marked core of the same epoch has been released.
- R5: Every request of epoch k is released before any request of epoch k+1.
- R6: An epoch whose mask is all zero is retired without releasing anything. It still advances the priority rotation by one step and never blocks the epochs behind it.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outSrc` and `outData` hold steady. At most one request is released per clock.
- R8: Some packets set the sticky `errFlag` and are dropped without ever being released. These are: a packet whose epoch is not pending, a packet whose mask bit is clear, a packet whose source is 36 or more, and a second packet for a slot that is already filled. Correct traffic never sets `errFlag`.
- R9: A packet must arrive at least one cycle after its mask was accepted. When its turn has already come, the packet is offered on `outValid` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| maskValid | input | 1 | An epoch notification mask is offered |
| maskBits | input | NUM_CORES | One bit per core that issued a request in the epoch |
| maskStall | output | 1 | Mask queue full; notifications are not accepted |
| pktValid | input | 1 | A request packet arrives this cycle |
| pktSrc | input | $clog2(NUM_CORES) | Source core of the packet |
| pktEpoch | input | EPOCH_W | Epoch tag of the packet |
| pktData | input | DATA_W | Request payload |
| outValid | output | 1 | A request is offered to the cache controller |
| outReady | input | 1 | Cache controller takes the offered request |
| outSrc | output | $clog2(NUM_CORES) | Source core of the offered request |
| outData | output | DATA_W | Payload of the offered request |
| errFlag | output | 1 | Sticky protocol-error flag |

## Verification
The bench sends a lower-priority packet ahead of a higher-priority one, both inside a plain epoch and across the wrap from core 35 to core 0. A sequencer that forwarded in arrival order, or that wrapped the rotation wrongly, would release the late-priority core first. Runs of empty epochs come before a two-core epoch, so a design that failed to advance the rotation on an empty epoch would release the two cores in the opposite order. The epoch tag is narrowed so that it wraps many times while the rotation keeps counting modulo 36. A design that derived the rotation from the tag would fall out of order after the first wrap. The bench also fills the mask queue and offers a mask during the stall; if that mask were accepted, a later packet would raise the error flag. Each kind of bad packet is sent on its own, and a design that stored any of them would release an unexpected source or payload.

// File: rtl/epochSeqPkg.sv
package epochSeqPkg;

  // Strobes from the ordering control to the storage datapath.
  typedef struct packed {
    logic pop;   // retire the head epoch
    logic rel;   // the offered request is taken this cycle
  } seqStrobe_t;

endpackage

// File: rtl/epochSeqDatapath.sv
module epochSeqDatapath
  import epochSeqPkg::*;
#(
  parameter int NUM_CORES = 36,
  parameter int EPOCH_W   = 8,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_CORES),
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 maskValid,
  input  logic [NUM_CORES-1:0] maskBits,
  output logic                 maskStall,
  input  logic                 pktValid,
  input  logic [SRC_W-1:0]     pktSrc,
  input  logic [EPOCH_W-1:0]   pktEpoch,
  input  logic [DATA_W-1:0]    pktData,
  input  seqStrobe_t           strobe,
  input  logic [SRC_W-1:0]     pickIdx,
  output logic                 headValid,
  output logic [NUM_CORES-1:0] headMask,
  output logic [NUM_CORES-1:0] headDone,
  output logic [NUM_CORES-1:0] headSeen,
  output logic [SRC_W-1:0]     headRot,
  output logic [DATA_W-1:0]    headData,
  output logic                 pktBad
);

  // Per pending epoch: marked cores, slots already filled, slots already released.
  logic [NUM_CORES-1:0] maskMem [DEPTH];
  logic [NUM_CORES-1:0] seenMem [DEPTH];
  logic [NUM_CORES-1:0] doneMem [DEPTH];
  logic [DATA_W-1:0]    dataMem [DEPTH][NUM_CORES];

  logic [PTR_W-1:0]   headPtr;
  logic [PTR_W-1:0]   tailPtr;
  logic [PTR_W-1:0]   pktSlot;
  logic [CNT_W-1:0]   count;
  logic [EPOCH_W-1:0] headEpoch;
  logic [EPOCH_W-1:0] epochOff;
  logic [SRC_W-1:0]   rot;
  logic               push;
  logic               srcOk;
  logic               inWindow;
  logic               pktGood;

  assign maskStall = (count == CNT_W'(DEPTH));
  assign push      = maskValid && !maskStall;

  // Locate the packet's epoch among the pending ones (head first).
  assign epochOff = pktEpoch - headEpoch;
  assign inWindow = epochOff < EPOCH_W'(count);
  assign pktSlot  = headPtr + epochOff[PTR_W-1:0];
  assign srcOk    = int'(pktSrc) < NUM_CORES;
  assign pktGood  = pktValid && srcOk && inWindow &&
                    maskMem[pktSlot][pktSrc] && !seenMem[pktSlot][pktSrc];
  assign pktBad   = pktValid && !pktGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      count     <= '0;
      headEpoch <= '0;
      rot       <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        maskMem[i] <= '0;
        seenMem[i] <= '0;
        doneMem[i] <= '0;
      end
    end else begin
      if (push) begin
        maskMem[tailPtr] <= maskBits;
        seenMem[tailPtr] <= '0;
        doneMem[tailPtr] <= '0;
        tailPtr          <= tailPtr + 1'b1;
      end
      if (pktGood) begin
        seenMem[pktSlot][pktSrc] <= 1'b1;
      end
      if (strobe.rel) begin
        doneMem[headPtr][pickIdx] <= 1'b1;
      end
      if (strobe.pop) begin
        headPtr   <= headPtr + 1'b1;
        headEpoch <= headEpoch + 1'b1;
        rot       <= (rot == SRC_W'(NUM_CORES - 1)) ? '0 : rot + 1'b1;
      end
      case ({push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // Payload slots need no reset: a slot is read only after its seen bit is set.
  always_ff @(posedge clk) begin
    if (pktGood) begin
      dataMem[pktSlot][pktSrc] <= pktData;
    end
  end

  assign headValid = (count != '0);
  assign headMask  = maskMem[headPtr];
  assign headDone  = doneMem[headPtr];
  assign headSeen  = seenMem[headPtr];
  assign headRot   = rot;
  assign headData  = dataMem[headPtr][pickIdx];

endmodule

// File: rtl/epochSeqControl.sv
module epochSeqControl
  import epochSeqPkg::*;
#(
  parameter int NUM_CORES = 36,
  localparam int SRC_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 headValid,
  input  logic [NUM_CORES-1:0] headMask,
  input  logic [NUM_CORES-1:0] headDone,
  input  logic [NUM_CORES-1:0] headSeen,
  input  logic [SRC_W-1:0]     headRot,
  input  logic                 pktBad,
  input  logic                 outReady,
  output seqStrobe_t           strobe,
  output logic [SRC_W-1:0]     pickIdx,
  output logic                 outValid,
  output logic                 errFlag
);

  logic [NUM_CORES-1:0] pending;
  logic                 found;
  logic [SRC_W-1:0]     cand;
  int                   scanIdx;

  assign pending = headMask & ~headDone;

  // First still-pending marked core at or after the rotation point, wrapping.
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    scanIdx = 0;
    cand    = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      scanIdx = int'(headRot) + i;
      if (scanIdx >= NUM_CORES) scanIdx = scanIdx - NUM_CORES;
      cand = SRC_W'(scanIdx);
      if (!found && pending[cand]) begin
        found   = 1'b1;
        pickIdx = cand;
      end
    end
  end

  // The chosen core blocks the epoch until its packet has been stored.
  assign outValid   = headValid && found && headSeen[pickIdx];
  assign strobe.rel = outValid && outReady;
  assign strobe.pop = headValid && (pending == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (pktBad) errFlag <= 1'b1;
  end

endmodule

// File: rtl/epochSequencer.sv
module epochSequencer
  import epochSeqPkg::*;
#(
  parameter int NUM_CORES = 36,
  parameter int EPOCH_W   = 8,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 maskValid,
  input  logic [NUM_CORES-1:0] maskBits,
  output logic                 maskStall,
  input  logic                 pktValid,
  input  logic [SRC_W-1:0]     pktSrc,
  input  logic [EPOCH_W-1:0]   pktEpoch,
  input  logic [DATA_W-1:0]    pktData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [SRC_W-1:0]     outSrc,
  output logic [DATA_W-1:0]    outData,
  output logic                 errFlag
);

  seqStrobe_t           strobe;
  logic [SRC_W-1:0]     pickIdx;
  logic                 headValid;
  logic [NUM_CORES-1:0] headMask;
  logic [NUM_CORES-1:0] headDone;
  logic [NUM_CORES-1:0] headSeen;
  logic [SRC_W-1:0]     headRot;
  logic                 pktBad;

  epochSeqDatapath #(
    .NUM_CORES(NUM_CORES), .EPOCH_W(EPOCH_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .maskValid(maskValid), .maskBits(maskBits), .maskStall(maskStall),
    .pktValid(pktValid), .pktSrc(pktSrc), .pktEpoch(pktEpoch), .pktData(pktData),
    .strobe(strobe), .pickIdx(pickIdx),
    .headValid(headValid), .headMask(headMask), .headDone(headDone),
    .headSeen(headSeen), .headRot(headRot), .headData(outData), .pktBad(pktBad)
  );

  epochSeqControl #(
    .NUM_CORES(NUM_CORES)
  ) uCtl (
    .clk(clk), .rstN(rstN),
    .headValid(headValid), .headMask(headMask), .headDone(headDone),
    .headSeen(headSeen), .headRot(headRot), .pktBad(pktBad), .outReady(outReady),
    .strobe(strobe), .pickIdx(pickIdx), .outValid(outValid), .errFlag(errFlag)
  );

  assign outSrc = pickIdx;

endmodule

// File: rtl/epochSeqChecker.sv
module epochSeqChecker #(
  parameter int NUM_CORES = 36,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_CORES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              maskValid,
  input logic              maskStall,
  input logic              pktValid,
  input logic              outValid,
  input logic              outReady,
  input logic [SRC_W-1:0]  outSrc,
  input logic [DATA_W-1:0] outData,
  input logic              errFlag
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && !maskStall && !errFlag));

  assert_stall_needs_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(maskStall) |-> $past(maskValid));

  assert_src_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outSrc) < NUM_CORES));

  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSrc) && $stable(outData)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(pktValid));

endmodule

bind epochSequencer epochSeqChecker #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .maskValid(maskValid), .maskStall(maskStall),
  .pktValid(pktValid), .outValid(outValid), .outReady(outReady),
  .outSrc(outSrc), .outData(outData), .errFlag(errFlag)
);

// File: tb/sim_epochSequencer.sv
`timescale 1ns/1ps
module sim_epochSequencer;
  localparam int N  = 36;
  localparam int EW = 5;
  localparam int DW = 32;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          maskValid = 1'b0;
  logic [N-1:0]  maskBits = '0;
  logic          maskStall;
  logic          pktValid = 1'b0;
  logic [SW-1:0] pktSrc = '0;
  logic [EW-1:0] pktEpoch = '0;
  logic [DW-1:0] pktData = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [SW-1:0] outSrc;
  logic [DW-1:0] outData;
  logic          errFlag;

  int total = 0;
  int bad = 0;
  int epochN = 0;
  int readyMode = 1;
  int unsigned seedDummy;
  int unsigned expSrc[$];
  logic [DW-1:0] expData[$];

  epochSequencer #(.NUM_CORES(N), .EPOCH_W(EW), .DEPTH(4), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .maskValid(maskValid), .maskBits(maskBits),
    .maskStall(maskStall), .pktValid(pktValid), .pktSrc(pktSrc),
    .pktEpoch(pktEpoch), .pktData(pktData), .outValid(outValid),
    .outReady(outReady), .outSrc(outSrc), .outData(outData), .errFlag(errFlag)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dataOf(input int n, input int c);
    logic [31:0] a;
    a = 32'(n) * 32'h9E3779B1 ^ 32'(c) * 32'h85EBCA6B;
    return a ^ 32'h00C0FFEE;
  endfunction

  function automatic logic [N-1:0] bitOf(input int c);
    return N'(1) << c;
  endfunction

  // Expected release order of epoch n: rotation start n mod N, then ascending with wrap.
  task automatic addExpected(input int n, input logic [N-1:0] m);
    for (int p = 0; p < N; p++) begin
      int c;
      c = (n % N + p) % N;
      if (m[c]) begin
        expSrc.push_back(c);
        expData.push_back(dataOf(n, c));
      end
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic sendMask(input logic [N-1:0] m);
    while (maskStall) @(negedge clk);
    maskValid = 1'b1;
    maskBits  = m;
    addExpected(epochN, m);
    epochN++;
    @(negedge clk);
    maskValid = 1'b0;
  endtask

  task automatic sendPkt(input int src, input int n, input logic [DW-1:0] d);
    pktValid = 1'b1;
    pktSrc   = SW'(src);
    pktEpoch = EW'(n);
    pktData  = d;
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic sendGood(input int src, input int n);
    sendPkt(src, n, dataOf(n, src));
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (expSrc.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(expSrc.size() == 0, tag, expSrc.size(), 0);
    idle(2);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    maskValid = 1'b0;
    pktValid = 1'b0;
    idle(3);
    expSrc.delete();
    expData.delete();
    epochN = 0;
    rstN = 1'b1;
    idle(1);
  endtask

  // Output monitor: drives outReady, then checks the transfer due at the next edge.
  logic          prevWait = 1'b0;
  logic [SW-1:0] prevSrc = '0;
  logic [DW-1:0] prevData = '0;
  always @(negedge clk) begin
    case (readyMode)
      0:       outReady = (($urandom % 4) != 0);
      1:       outReady = 1'b1;
      default: outReady = 1'b0;
    endcase
    #1;
    if (!rstN) begin
      prevWait = 1'b0;
    end else begin
      if (prevWait) begin
        chk(outValid && outSrc == prevSrc && outData == prevData,
            "R7 offer held while not ready", outSrc, prevSrc);
      end
      if (outValid && outReady) begin
        if (expSrc.size() == 0) begin
          chk(1'b0, "R8 unexpected release", outSrc, 99);
        end else begin
          chk(outSrc == SW'(expSrc[0]), "R4 R5 release order", outSrc, expSrc[0]);
          chk(outData == expData[0], "R2 released payload", outData, expData[0]);
          void'(expSrc.pop_front());
          void'(expData.pop_front());
        end
      end
      prevWait = outValid && !outReady;
      prevSrc  = outSrc;
      prevData = outData;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd20240611);
    readyMode = 1;
    idle(3);
    chk(!outValid && !maskStall && !errFlag, "R1 outputs in reset",
        {outValid, maskStall, errFlag}, 0);
    rstN = 1'b1;
    idle(1);
    chk(!outValid, "R1 outValid after reset", outValid, 0);
    chk(!maskStall, "R1 maskStall after reset", maskStall, 0);
    chk(!errFlag, "R1 errFlag after reset", errFlag, 0);

    // Epoch 0, rotation 0: core 2 outranks core 30.
    sendMask(bitOf(2) | bitOf(30));
    sendGood(30, 0);
    idle(4);
    chk(!outValid, "R4 lower priority held", outValid, 0);
    sendGood(2, 0);
    chk(outValid && outSrc == 2, "R9 offered next cycle", outSrc, 2);
    drain("R4 drain epoch 0");

    // Epoch 1, rotation 1: core 35 outranks core 0 across the wrap.
    sendMask(bitOf(0) | bitOf(35));
    sendGood(0, 1);
    idle(4);
    chk(!outValid, "R4 wrap priority held", outValid, 0);
    sendGood(35, 1);
    drain("R4 drain epoch 1");

    // Empty epochs 2..4, then epoch 5 (rotation 5): core 5 before core 4.
    sendMask('0);
    sendMask('0);
    sendMask('0);
    idle(3);
    chk(!maskStall && !outValid, "R6 empty epochs retired", {maskStall, outValid}, 0);
    sendMask(bitOf(4) | bitOf(5));
    sendGood(4, 5);
    idle(3);
    chk(!outValid, "R6 rotation advanced by empty epochs", outValid, 0);
    sendGood(5, 5);
    drain("R6 drain epoch 5");

    // Fill the mask queue with epochs 6..9, offer an extra mask while stalled.
    for (int e = 0; e < 4; e++) sendMask(bitOf(0));
    chk(maskStall, "R3 stall with four pending", maskStall, 1);
    maskValid = 1'b1;
    maskBits  = bitOf(2);
    idle(2);
    maskValid = 1'b0;
    chk(maskStall, "R3 stall holds", maskStall, 1);
    for (int e = 6; e < 10; e++) sendGood(0, e);
    drain("R3 drain stalled epochs");
    chk(!maskStall, "R3 stall clears", maskStall, 0);
    sendMask(bitOf(1));
    sendGood(1, 10);
    drain("R3 drain epoch 10");
    chk(!errFlag, "R3 ignored mask took no epoch", errFlag, 0);

    // Random traffic; epoch tags wrap many times.
    doReset();
    readyMode = 0;
    for (int b = 0; b < 60; b++) begin
      int k;
      int sel;
      int j;
      int t;
      logic [N-1:0] m;
      int pc[$];
      int pn[$];
      pc.delete();
      pn.delete();
      k = 1 + int'($urandom % 3);
      for (int e = 0; e < k; e++) begin
        sel = int'($urandom % 6);
        if (sel == 0) m = '0;
        else if (sel == 1) m = bitOf(int'($urandom % N));
        else if (sel == 2) m = N'({$urandom, $urandom});
        else m = N'({$urandom, $urandom} & {$urandom, $urandom});
        for (int c = 0; c < N; c++) begin
          if (m[c]) begin
            pc.push_back(c);
            pn.push_back(epochN);
          end
        end
        sendMask(m);
      end
      for (int i = pc.size() - 1; i > 0; i--) begin
        j = int'($urandom % (i + 1));
        t = pc[i]; pc[i] = pc[j]; pc[j] = t;
        t = pn[i]; pn[i] = pn[j]; pn[j] = t;
      end
      for (int i = 0; i < pc.size(); i++) begin
        sendGood(pc[i], pn[i]);
        idle(int'($urandom % 3));
      end
      drain("R5 random batch drain");
    end
    readyMode = 1;
    idle(2);
    chk(!errFlag, "R8 no error on correct traffic", errFlag, 0);

    // Packet before any mask.
    doReset();
    sendPkt(3, 0, dataOf(0, 3));
    chk(errFlag, "R8 packet with no pending epoch", errFlag, 1);
    idle(3);
    chk(!outValid, "R8 dropped packet not offered", outValid, 0);

    // Packet whose mask bit is clear.
    doReset();
    sendMask(bitOf(5));
    sendPkt(6, 0, dataOf(0, 6));
    chk(errFlag, "R8 unmarked source", errFlag, 1);
    idle(3);
    chk(!outValid, "R8 unmarked packet dropped", outValid, 0);
    sendGood(5, 0);
    drain("R8 drain after unmarked");

    // Duplicate for a filled slot; the first copy must survive.
    doReset();
    readyMode = 2;
    sendMask(bitOf(3) | bitOf(7));
    sendGood(3, 0);
    chk(!errFlag, "R8 first copy accepted", errFlag, 0);
    sendPkt(3, 0, 32'hDEADBEEF);
    chk(errFlag, "R8 duplicate flagged", errFlag, 1);
    readyMode = 1;
    sendGood(7, 0);
    drain("R8 drain after duplicate");

    // Source index out of range.
    doReset();
    sendMask(bitOf(4));
    sendPkt(40, 0, dataOf(0, 40));
    chk(errFlag, "R8 source out of range", errFlag, 1);
    sendGood(4, 0);
    drain("R8 drain after bad source");

    // Epoch tag not yet pending.
    doReset();
    sendMask(bitOf(1));
    sendPkt(1, 1, dataOf(1, 1));
    chk(errFlag, "R8 future epoch tag", errFlag, 1);
    idle(3);
    chk(!outValid, "R8 future packet dropped", outValid, 0);
    sendGood(1, 0);
    drain("R8 drain after future tag");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule